// File: doc/BRIEF.md
# Four-Channel Fly-By DMA Controller

This block moves data between memory and peripherals on behalf of the processor. When a programmed channel sees its peripheral request, the controller asks for the system bus. Once the processor grants it, the controller drives one memory address per cycle. In the same cycle it asserts a memory strobe and the opposite I/O strobe, so the data passes straight from one device to the other without being held in the controller. A per-channel acknowledge selects the peripheral.

Software programs each channel through a small byte-wide register port. Each channel has a 16-bit start address and a 16-bit transfer count, both loaded as two byte writes, and a mode byte. The mode byte sets one of three bus-release policies and the transfer direction. A transfer program ends either at terminal count, when the controller pulls the shared end-of-process line low, or when some other agent pulls that line low.

Top module: `dmac_top`

## Requirements
- R1: Register addresses 0 to 7 hold data registers. Offset 2n is the address of channel n and offset 2n+1 is its count. A write there loads the base copy and the current copy of that register together. Reads at 0 to 7 return the current copy, and reads at 8 to 15 return the base copy with the same offset layout.
- R2: Every 16-bit register is accessed as two bytes, low byte first, through one shared byte pointer. The pointer flips on each data-register write and on every read. A write to address 12 returns it to the low byte. Reset also returns it to the low byte.
- R3: `hold` rises when an armed channel has its request line high. Address, DACK and strobes are active only while `holda` is high during a transfer cycle. Otherwise `addr_oe` is 0, `dack` is 0 and all four strobes are high.
- R4: In each transfer cycle, `addr_out` carries the channel's current address and exactly one `dack` bit is high, the one for that channel. Mode bit 2 clear pairs `memrd_n` with `iowr_n`. Mode bit 2 set pairs `iord_n` with `memwr_n`. Both strobes of a pair are low in the same cycle.
- R5: The channel is chosen when the bus is granted, by fixed priority: channel 0 highest, channel 3 lowest.
- R6: Each transfer adds one to the current address and subtracts one from the current count. A count of N gives N+1 transfers. The last of them drives `eop_drive` for exactly that cycle and disarms the channel. A disarmed channel ignores its request line until its count high byte is written again.
- R7: Mode bits [1:0] = 00 (single; 11 behaves the same) performs one transfer and then drops `hold` for at least one cycle before asking again.
- R8: Mode bits [1:0] = 01 (demand) performs back-to-back transfers while the channel's request line stays high. When the request line drops, the bus is released and the channel stays armed with its updated registers.
- R9: Mode bits [1:0] = 10 (block) performs back-to-back transfers to terminal count, whatever the request line does after the bus was granted.
- R10: If `eop_in_n` is low during a transfer cycle, that transfer is the last one. The channel is disarmed, the bus is released, and `eop_drive` stays low.
- R11: The mode byte of channel n is written at address 8+n. After reset all registers, modes and arming are zero and `hold` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write byte |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (advances byte pointer) |
| reg_rdata | output | 8 | Register read byte |
| dreq | input | 4 | Peripheral request per channel |
| dack | output | 4 | Peripheral acknowledge per channel |
| hold | output | 1 | Bus request to processor |
| holda | input | 1 | Bus grant from processor |
| addr_oe | output | 1 | Drive enable for address and strobes |
| addr_out | output | 16 | Memory address |
| memrd_n | output | 1 | Memory read strobe, active low |
| memwr_n | output | 1 | Memory write strobe, active low |
| iord_n | output | 1 | I/O read strobe, active low |
| iowr_n | output | 1 | I/O write strobe, active low |
| eop_in_n | input | 1 | Observed level of end-of-process line |
| eop_drive | output | 1 | Pull end-of-process line low |

## Verification
The bench builds the controller with its default of four channels. With four channels, priority can be tested between two non-adjacent channels that request in the same cycle, and each mode can run on a different channel. A start address of 0xFFFE shows the address wrapping across the 16-bit boundary. Reading the registers back after a demand pause and after an external end-of-process shows how many transfers each one left outstanding.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'b00,
        XM_DEMAND = 2'b01,
        XM_BLOCK  = 2'b10,
        XM_RSVD   = 2'b11
    } xfer_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ASK,
        SQ_MOVE,
        SQ_FREE
    } seq_state_e;

    typedef struct packed {
        xfer_mode_e mode;
        logic       io_to_mem;
    } chan_cfg_t;

    typedef struct packed {
        logic memrd_n;
        logic memwr_n;
        logic iord_n;
        logic iowr_n;
    } strobe_t;

    function automatic xfer_mode_e decode_mode(input logic [1:0] f);
        xfer_mode_e m;
        case (f)
            2'b01:   m = XM_DEMAND;
            2'b10:   m = XM_BLOCK;
            default: m = XM_SINGLE;
        endcase
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] put_byte(input logic [WORD_W-1:0] w,
                                                   input logic hi,
                                                   input logic [BYTE_W-1:0] b);
        return hi ? {b, w[BYTE_W-1:0]} : {w[WORD_W-1:BYTE_W], b};
    endfunction

    function automatic strobe_t pair_strobes(input logic on, input logic io_to_mem);
        strobe_t s;
        s = '{memrd_n: 1'b1, memwr_n: 1'b1, iord_n: 1'b1, iowr_n: 1'b1};
        if (on) begin
            if (io_to_mem) begin
                s.iord_n  = 1'b0;
                s.memwr_n = 1'b0;
            end else begin
                s.memrd_n = 1'b0;
                s.iowr_n  = 1'b0;
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH),
    localparam int RAW = CHW + 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [RAW-1:0]               rg_addr,
    input  logic [BYTE_W-1:0]            rg_wdata,
    input  logic                         rg_we,
    input  logic                         rg_re,
    output logic [BYTE_W-1:0]            rg_rdata,
    input  logic                         step,
    input  logic [CHW-1:0]               step_ch,
    input  logic                         finish,
    output logic [NCH-1:0][WORD_W-1:0]   cur_addr_o,
    output logic [NCH-1:0]               cnt_zero_o,
    output logic [NCH-1:0]               armed_o,
    output chan_cfg_t [NCH-1:0]          cfg_o
);

    logic [WORD_W-1:0] base_a [NCH];
    logic [WORD_W-1:0] cur_a  [NCH];
    logic [WORD_W-1:0] base_c [NCH];
    logic [WORD_W-1:0] cur_c  [NCH];
    chan_cfg_t         cfg_q  [NCH];
    logic              armed_q[NCH];
    logic              byte_hi;

    logic           is_data;
    logic [CHW-1:0] dsel;
    logic           field_cnt;
    logic           data_wr;
    logic           mode_wr;
    logic           ptr_clr;

    assign is_data   = !rg_addr[RAW-1];
    assign dsel      = rg_addr[RAW-2:1];
    assign field_cnt = rg_addr[0];
    assign data_wr   = rg_we && is_data;
    assign mode_wr   = rg_we && rg_addr[RAW-1] && !rg_addr[RAW-2];
    assign ptr_clr   = rg_we && rg_addr[RAW-1] && rg_addr[RAW-2]
                       && (rg_addr[CHW-1:0] == '0);

    // shared low/high byte pointer
    always_ff @(posedge clk) begin
        if (rst)                   byte_hi <= 1'b0;
        else if (ptr_clr)          byte_hi <= 1'b0;
        else if (data_wr || rg_re) byte_hi <= ~byte_hi;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        always_ff @(posedge clk) begin
            if (rst) begin
                base_a[c]  <= '0;
                cur_a[c]   <= '0;
                base_c[c]  <= '0;
                cur_c[c]   <= '0;
                cfg_q[c]   <= '{mode: XM_SINGLE, io_to_mem: 1'b0};
                armed_q[c] <= 1'b0;
            end else begin
                if (step && step_ch == CHW'(c)) begin
                    cur_a[c] <= cur_a[c] + 1'b1;
                    cur_c[c] <= cur_c[c] - 1'b1;
                    if (finish) armed_q[c] <= 1'b0;
                end
                if (data_wr && dsel == CHW'(c)) begin
                    if (field_cnt) begin
                        base_c[c] <= put_byte(base_c[c], byte_hi, rg_wdata);
                        cur_c[c]  <= put_byte(base_c[c], byte_hi, rg_wdata);
                        if (byte_hi) armed_q[c] <= 1'b1;
                    end else begin
                        base_a[c] <= put_byte(base_a[c], byte_hi, rg_wdata);
                        cur_a[c]  <= put_byte(base_a[c], byte_hi, rg_wdata);
                    end
                end
                if (mode_wr && rg_addr[CHW-1:0] == CHW'(c)) begin
                    cfg_q[c] <= '{mode: decode_mode(rg_wdata[1:0]),
                                  io_to_mem: rg_wdata[2]};
                end
            end
        end

        assign cur_addr_o[c] = cur_a[c];
        assign cnt_zero_o[c] = (cur_c[c] == '0);
        assign armed_o[c]    = armed_q[c];
        assign cfg_o[c]      = cfg_q[c];
    end

    // read-back: current copy in the low half of the map, base copy in the upper half
    logic [WORD_W-1:0] rd_word;
    always_comb begin
        if (rg_addr[RAW-1])
            rd_word = field_cnt ? base_c[dsel] : base_a[dsel];
        else
            rd_word = field_cnt ? cur_c[dsel] : cur_a[dsel];
        rg_rdata = byte_hi ? rd_word[WORD_W-1:BYTE_W] : rd_word[BYTE_W-1:0];
    end

endmodule

// File: rtl/dmac_prio.sv
module dmac_prio #(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           grant_vld,
    output logic [CHW-1:0] grant_idx
);

    always_comb begin
        grant_idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) grant_idx = CHW'(i);
        end
        grant_vld = |req;
    end

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NCH-1:0]              dreq,
    input  logic [NCH-1:0]              pending,
    input  logic                        grant_vld,
    input  logic [CHW-1:0]              grant_idx,
    input  logic [NCH-1:0][WORD_W-1:0]  cur_addr,
    input  logic [NCH-1:0]              cnt_zero,
    input  chan_cfg_t [NCH-1:0]         cfg,
    input  logic                        holda,
    input  logic                        eop_in_n,
    output logic                        hold,
    output logic                        bus_en,
    output logic [CHW-1:0]              act_ch,
    output logic                        step,
    output logic                        finish,
    output logic [NCH-1:0]              dack,
    output logic [WORD_W-1:0]           addr_out,
    output strobe_t                     strobes,
    output logic                        eop_drive
);

    seq_state_e st, nx;
    logic [CHW-1:0] ch_q;
    logic last;
    chan_cfg_t ccfg;

    assign ccfg   = cfg[ch_q];
    assign bus_en = (st == SQ_MOVE) && holda;
    assign last   = cnt_zero[ch_q] || !eop_in_n;
    assign step   = bus_en;
    assign finish = bus_en && last;
    assign act_ch = ch_q;
    assign hold   = (st == SQ_ASK) || (st == SQ_MOVE);

    always_comb begin
        nx = st;
        case (st)
            SQ_IDLE: if (|pending) nx = SQ_ASK;
            SQ_ASK:  if (holda) nx = grant_vld ? SQ_MOVE : SQ_FREE;
            SQ_MOVE: begin
                if (holda) begin
                    if (last) nx = SQ_FREE;
                    else begin
                        case (ccfg.mode)
                            XM_DEMAND: nx = dreq[ch_q] ? SQ_MOVE : SQ_FREE;
                            XM_BLOCK:  nx = SQ_MOVE;
                            default:   nx = SQ_FREE;
                        endcase
                    end
                end
            end
            default: nx = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= SQ_IDLE;
            ch_q <= '0;
        end else begin
            st <= nx;
            if (st == SQ_ASK && holda && grant_vld) ch_q <= grant_idx;
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) dack[i] = bus_en && (ch_q == CHW'(i));
        addr_out  = bus_en ? cur_addr[ch_q] : '0;
        strobes   = pair_strobes(bus_en, ccfg.io_to_mem);
        eop_drive = bus_en && cnt_zero[ch_q];
    end

endmodule

// File: rtl/dmac_top.sv
module dmac_top
    import dmac_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = $clog2(NCH),
    localparam int RAW = CHW + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [RAW-1:0]    reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic [NCH-1:0]    dreq,
    output logic [NCH-1:0]    dack,
    output logic              hold,
    input  logic              holda,
    output logic              addr_oe,
    output logic [WORD_W-1:0] addr_out,
    output logic              memrd_n,
    output logic              memwr_n,
    output logic              iord_n,
    output logic              iowr_n,
    input  logic              eop_in_n,
    output logic              eop_drive
);

    logic [NCH-1:0][WORD_W-1:0] cur_addr;
    logic [NCH-1:0]             cnt_zero;
    logic [NCH-1:0]             armed;
    chan_cfg_t [NCH-1:0]        cfg;
    logic [NCH-1:0]             pending;
    logic                       grant_vld;
    logic [CHW-1:0]             grant_idx;
    logic                       step, finish;
    logic [CHW-1:0]             act_ch;
    strobe_t                    strobes;

    assign pending = dreq & armed;

    dmac_regs #(.NCH(NCH)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .rg_addr    (reg_addr),
        .rg_wdata   (reg_wdata),
        .rg_we      (reg_we),
        .rg_re      (reg_re),
        .rg_rdata   (reg_rdata),
        .step       (step),
        .step_ch    (act_ch),
        .finish     (finish),
        .cur_addr_o (cur_addr),
        .cnt_zero_o (cnt_zero),
        .armed_o    (armed),
        .cfg_o      (cfg)
    );

    dmac_prio #(.NCH(NCH)) u_prio (
        .req       (pending),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    dmac_seq #(.NCH(NCH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .dreq      (dreq),
        .pending   (pending),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx),
        .cur_addr  (cur_addr),
        .cnt_zero  (cnt_zero),
        .cfg       (cfg),
        .holda     (holda),
        .eop_in_n  (eop_in_n),
        .hold      (hold),
        .bus_en    (addr_oe),
        .act_ch    (act_ch),
        .step      (step),
        .finish    (finish),
        .dack      (dack),
        .addr_out  (addr_out),
        .strobes   (strobes),
        .eop_drive (eop_drive)
    );

    assign memrd_n = strobes.memrd_n;
    assign memwr_n = strobes.memwr_n;
    assign iord_n  = strobes.iord_n;
    assign iowr_n  = strobes.iowr_n;

endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
    parameter int NCH = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           hold,
    input logic           holda,
    input logic           addr_oe,
    input logic [NCH-1:0] dack,
    input logic           memrd_n,
    input logic           memwr_n,
    input logic           iord_n,
    input logic           iowr_n,
    input logic           eop_drive
);

    AST_BUS_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        addr_oe |-> (hold && holda)); // R3

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !addr_oe |-> (dack == '0 && memrd_n && memwr_n && iord_n && iowr_n)); // R3

    AST_SINGLE_ACK: assert property (@(posedge clk) disable iff (rst)
        addr_oe |-> ($countones(dack) == 1)); // R4

    AST_STROBE_PAIR: assert property (@(posedge clk) disable iff (rst)
        addr_oe |-> ((!memrd_n && !iowr_n && memwr_n && iord_n) ||
                     (!iord_n && !memwr_n && memrd_n && iowr_n))); // R4

    AST_EOP_IN_XFER: assert property (@(posedge clk) disable iff (rst)
        eop_drive |-> addr_oe); // R6

    AST_EOP_PULSE: assert property (@(posedge clk) disable iff (rst)
        eop_drive |=> !eop_drive); // R6

    AST_RELEASE_AT_END: assert property (@(posedge clk) disable iff (rst)
        eop_drive |=> !hold); // R6

endmodule

bind dmac_top dmac_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hold      (hold),
    .holda     (holda),
    .addr_oe   (addr_oe),
    .dack      (dack),
    .memrd_n   (memrd_n),
    .memwr_n   (memwr_n),
    .iord_n    (iord_n),
    .iowr_n    (iowr_n),
    .eop_drive (eop_drive)
);

// File: tb/dmac_top_test.sv
module dmac_top_test;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_we, reg_re;
    logic [7:0]  reg_rdata;
    logic [3:0]  dreq;
    logic [3:0]  dack;
    logic        hold, holda, addr_oe;
    logic [15:0] addr_out;
    logic        memrd_n, memwr_n, iord_n, iowr_n;
    logic        eop_in_n, eop_drive;

    always #5 clk = ~clk;

    dmac_top #(.NCH(4)) uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
        .dreq(dreq), .dack(dack), .hold(hold), .holda(holda),
        .addr_oe(addr_oe), .addr_out(addr_out), .memrd_n(memrd_n),
        .memwr_n(memwr_n), .iord_n(iord_n), .iowr_n(iowr_n),
        .eop_in_n(eop_in_n), .eop_drive(eop_drive)
    );

    int n_chk = 0;
    int n_err = 0;
    int n_xfer, n_eop, n_rel, pair_bad;
    logic [15:0] first_addr, last_addr;
    logic [3:0]  first_dack, last_dack;
    logic        prev_hold = 1'b0;
    logic        exp_dir = 1'b0;
    logic        ack_en = 1'b1;

    // fields: channel, mode, direction, start address, count
    localparam logic [36:0] VECS [4] = '{
        {2'd2, 2'b00, 1'b0, 16'h1000, 16'd2},
        {2'd1, 2'b01, 1'b1, 16'h20FE, 16'd4},
        {2'd3, 2'b10, 1'b0, 16'hFFFE, 16'd3},
        {2'd0, 2'b10, 1'b1, 16'h0040, 16'd0}
    };

    // processor model: grants the bus one cycle after the request
    always @(posedge clk) begin
        if (rst) holda <= 1'b0;
        else     holda <= hold && ack_en;
    end

    // bus monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (addr_oe) begin
                if (n_xfer == 0) begin
                    first_addr = addr_out;
                    first_dack = dack;
                end
                n_xfer++;
                last_addr = addr_out;
                last_dack = dack;
                if ({memrd_n, memwr_n, iord_n, iowr_n} != (exp_dir ? 4'b1001 : 4'b0110))
                    pair_bad++;
            end
            if (eop_drive) n_eop++;
            if (prev_hold && !hold) n_rel++;
            prev_hold = hold;
        end
    end

    task automatic tick;
        @(negedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        tick;
        reg_addr  = a[3:0];
        reg_wdata = d[7:0];
        reg_we    = 1'b1;
        tick;
        reg_we    = 1'b0;
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        tick;
        reg_addr = a[3:0];
        reg_re   = 1'b1;
        #1 v = reg_rdata;
        tick;
        reg_re   = 1'b0;
    endtask

    task automatic rd16(input int a, output logic [15:0] v);
        logic [7:0] lo, hi;
        wr(12, 0);
        rd(a, lo);
        rd(a, hi);
        v = {hi, lo};
    endtask

    task automatic setup(input int ch, input int mode, input int dir,
                         input logic [15:0] a, input logic [15:0] c);
        wr(12, 0);
        wr(8 + ch, (dir << 2) | mode);
        wr(2 * ch, a[7:0]);
        wr(2 * ch, a[15:8]);
        wr(2 * ch + 1, c[7:0]);
        wr(2 * ch + 1, c[15:8]);
    endtask

    task automatic clear_mon;
        n_xfer = 0; n_eop = 0; n_rel = 0; pair_bad = 0;
        first_dack = '0; last_dack = '0;
    endtask

    task automatic wait_eop(input int n);
        int g = 0;
        while (n_eop < n && g < 2000) begin
            tick;
            g++;
        end
    endtask

    task automatic wait_xfer(input int n);
        int g = 0;
        while (n_xfer < n && g < 2000) begin
            tick;
            g++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v16;
        rst = 1'b1; reg_addr = '0; reg_wdata = '0; reg_we = 1'b0; reg_re = 1'b0;
        dreq = '0; eop_in_n = 1'b1;
        clear_mon();
        repeat (3) tick;
        rst = 1'b0;
        tick;

        // R11: reset state
        chk("R11 hold", hold, 0);
        chk("R11 bus off", {addr_oe, dack}, 0);
        chk("R11 strobes", {memrd_n, memwr_n, iord_n, iowr_n}, 4'hF);
        chk("R11 eop", eop_drive, 0);
        rd16(1, v16);
        chk("R11 count ch0", v16, 0);

        // R1 / R2: byte pointer, clear, base and current copies
        wr(12, 0);
        wr(0, 8'h34);
        wr(12, 0);
        wr(0, 8'h78);
        wr(0, 8'h56);
        rd16(0, v16);
        chk("R2 low-high order", v16, 16'h5678);
        rd16(8, v16);
        chk("R1 base copy", v16, 16'h5678);

        // table of scenarios
        for (int i = 0; i < 4; i++) begin
            logic [1:0]  vch, vmode;
            logic        vdir;
            logic [15:0] va, vc, exp_last, exp_next;
            string       rtag;
            {vch, vmode, vdir, va, vc} = VECS[i];
            rtag = (vmode == 2'b00) ? "R7" : (vmode == 2'b01) ? "R8" : "R9";
            exp_dir = vdir;
            exp_last = va + vc;
            exp_next = va + vc + 16'd1;
            setup(vch, vmode, vdir, va, vc);
            clear_mon();
            dreq[vch] = 1'b1;
            if (vmode == 2'b10) begin
                wait_xfer(1);
                dreq[vch] = 1'b0;
            end
            wait_eop(1);
            repeat (6) tick;
            chk({rtag, " transfers"}, n_xfer, vc + 1);
            chk({rtag, " releases"}, n_rel, (vmode == 2'b00) ? vc + 1 : 1);
            chk("R4 last address", last_addr, exp_last);
            chk("R4 dack", last_dack, 4'b1 << vch);
            chk("R4 strobe pairing", pair_bad, 0);
            chk("R6 eop pulses", n_eop, 1);
            chk("R6 disarmed", hold, 0);
            dreq = '0;
            rd16(2 * vch + 1, v16);
            chk("R6 count underflow", v16, 16'hFFFF);
            rd16(2 * vch, v16);
            chk("R6 address advanced", v16, exp_next);
        end

        // R3: nothing driven until the grant
        ack_en = 1'b0;
        exp_dir = 1'b0;
        setup(0, 0, 0, 16'h0500, 16'd0);
        clear_mon();
        dreq = 4'b0001;
        repeat (5) tick;
        chk("R3 hold raised", hold, 1);
        chk("R3 no bus before grant", {addr_oe, dack}, 0);
        chk("R3 strobes idle", {memrd_n, memwr_n, iord_n, iowr_n}, 4'hF);
        ack_en = 1'b1;
        wait_eop(1);
        repeat (3) tick;
        chk("R3 transfer after grant", n_xfer, 1);
        dreq = '0;

        // R5: fixed priority at grant
        setup(1, 2, 0, 16'h0100, 16'd1);
        setup(3, 2, 0, 16'h0300, 16'd1);
        clear_mon();
        dreq = 4'b1010;
        wait_eop(2);
        repeat (3) tick;
        chk("R5 first dack", first_dack, 4'b0010);
        chk("R5 first address", first_addr, 16'h0100);
        chk("R5 total transfers", n_xfer, 4);
        chk("R5 second channel", last_dack, 4'b1000);
        dreq = '0;

        // R8: demand pause and resume
        exp_dir = 1'b1;
        setup(2, 1, 1, 16'h0A00, 16'd5);
        clear_mon();
        dreq[2] = 1'b1;
        wait_xfer(2);
        dreq[2] = 1'b0;
        repeat (4) tick;
        chk("R8 pause transfers", n_xfer, 2);
        chk("R8 bus released", hold, 0);
        chk("R8 no eop on pause", n_eop, 0);
        rd16(5, v16);
        chk("R8 remaining count", v16, 16'd3);
        dreq[2] = 1'b1;
        wait_eop(1);
        repeat (3) tick;
        chk("R8 resumed total", n_xfer, 6);
        chk("R8 resumed last address", last_addr, 16'h0A05);
        chk("R8 pairing", pair_bad, 0);
        dreq = '0;

        // R10: external end-of-process
        exp_dir = 1'b0;
        setup(0, 2, 0, 16'h0C00, 16'd10);
        clear_mon();
        dreq[0] = 1'b1;
        wait_xfer(3);
        eop_in_n = 1'b0;
        tick;
        eop_in_n = 1'b1;
        repeat (6) tick;
        chk("R10 transfers", n_xfer, 3);
        chk("R10 no own eop", n_eop, 0);
        chk("R10 disarmed", hold, 0);
        rd16(1, v16);
        chk("R10 count left", v16, 16'd7);
        dreq = '0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule